// File: doc/BRIEF.md
# Character display bring-up and refresh sequencer

This block brings a two-row character display out of reset and keeps it filled with text. After a start pulse it issues four configuration commands over a request/done handshake to a separate bus engine. Those commands set the bus width, line count and font, turn the display on, set the entry mode and clear the screen. Each command is followed by a fixed settling delay, and the clear command gets a longer one. The block then selects the start of the first row and streams one row of character codes. It does the same for the second row, then pauses and runs the whole pass again without needing a new start.

Character codes come from a small read-only text store addressed as row times row length plus column. The store is read combinationally: the byte on `romData` must belong to the address on `romAddr` in the same cycle. Bus timing, busy polling, text updates and glyph loading belong to other blocks. A fixed delay stands in for the busy flag.

All delays are given as clock counts through parameters. The defaults assume a 50 MHz clock: about 40 µs per command, about 1.64 ms after the clear, and about 5 ms between passes.

Top module: `charLcdSequencer`

## Requirements
- R1: After synchronous reset `req` and `frameDone` are low, and `req` stays low until `start` is seen high on a clock edge. `req` goes high in the cycle right after that edge.
- R2: Every pass begins with four commands (`cmdIsData`=0), in this order: 0x38, 0x0E, 0x06, 0x01.
- R3: `req` drops on the edge that accepts `xferDone`. It rises again exactly CLEAR_WAIT edges later after the 0x01 command, and exactly SHORT_WAIT edges later after every other transfer except the last of a pass.
- R4: After the configuration commands come the command 0x80, then LINE_CHARS data transfers (`cmdIsData`=1), then the command 0xC0, then LINE_CHARS more data transfers.
- R5: For the data transfer at column c of row r (r = 0 or 1), `romAddr` equals r*LINE_CHARS + c while `req` is high, and `cmdByte` equals `romData`.
- R6: While `req` is high and `xferDone` is low, `req`, `cmdByte` and `cmdIsData` hold their values. A `xferDone` pulse while `req` is low has no effect on the sequence or its timing.
- R7: After the final data transfer of a pass is accepted, `frameDone` is high for exactly one cycle. That cycle follows the edge SHORT_WAIT edges after the accepting edge. `req` rises again SHORT_WAIT+PAUSE_WAIT edges after the accepting edge, with 0x38 and no new start.
- R8: `start` has no effect once the sequencer is running.
- R9: A synchronous reset in the middle of a pass returns the block to idle with `req` and `frameDone` low. The next start begins again with 0x38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins the first pass when idle |
| req | output | 1 | Transfer request to the bus engine |
| cmdIsData | output | 1 | 1: data write, 0: command write |
| cmdByte | output | 8 | Byte to transfer |
| xferDone | input | 1 | One-cycle pulse from the bus engine when the transfer is finished |
| romAddr | output | ROM_AW | Text store address |
| romData | input | 8 | Text store byte for `romAddr`, same cycle |
| frameDone | output | 1 | One-cycle pulse at the end of each pass |

## Verification
The bench plays the bus engine, and the delay before it answers each request cycles through zero to three clocks. This separates the timing of the handshake from the delay counters. The text store returns a distinct code for every address, so a wrong address or a row swap shows up as a wrong byte. Stray done pulses and start pulses are inserted during the delays and while a request is pending. The gap lengths then show whether they were ignored. The bench runs more than two passes and breaks one pass with a reset. This exercises the clear-delay, pass-pause and restart paths, and the single end-of-pass pulse.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_PAUSE
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrIdx;
    logic advIdx;
    logic loadShort;
    logic loadClear;
    logic loadPause;
    logic decTimer;
  } dpCtrl_t;

endpackage

// File: rtl/lcdseqCtrl.sv
module lcdseqCtrl
  import lcdseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    xferDone,
  input  logic    timerLast,
  input  logic    isClearItem,
  input  logic    isLastItem,
  output dpCtrl_t ctrl,
  output logic    req,
  output logic    frameDone
);

  seqState_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      case (state)
        ST_IDLE:  if (start) state <= ST_ISSUE;
        ST_ISSUE: if (xferDone) state <= ST_WAIT;
        ST_WAIT: begin
          if (timerLast) begin
            if (isLastItem) begin
              state     <= ST_PAUSE;
              frameDone <= 1'b1;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        ST_PAUSE: if (timerLast) state <= ST_ISSUE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl = '0;
    case (state)
      ST_IDLE: ctrl.clrIdx = 1'b1;
      ST_ISSUE: begin
        if (xferDone) begin
          if (isClearItem) ctrl.loadClear = 1'b1;
          else             ctrl.loadShort = 1'b1;
        end
      end
      ST_WAIT: begin
        if (timerLast) begin
          if (isLastItem) begin
            ctrl.clrIdx    = 1'b1;
            ctrl.loadPause = 1'b1;
          end else begin
            ctrl.advIdx = 1'b1;
          end
        end else begin
          ctrl.decTimer = 1'b1;
        end
      end
      ST_PAUSE: if (!timerLast) ctrl.decTimer = 1'b1;
      default: ctrl = '0;
    endcase
  end

  assign req = (state == ST_ISSUE);

endmodule

// File: rtl/lcdseqDatapath.sv
module lcdseqDatapath
  import lcdseq_pkg::*;
#(
  parameter int          LINE_CHARS = 40,
  parameter int          SHORT_WAIT = 2000,
  parameter int          CLEAR_WAIT = 82000,
  parameter int          PAUSE_WAIT = 250000,
  parameter logic [7:0]  CMD_FUNC   = 8'h38,
  parameter logic [7:0]  CMD_DISP   = 8'h0E,
  parameter logic [7:0]  CMD_ENTRY  = 8'h06,
  parameter logic [7:0]  CMD_CLEAR  = 8'h01,
  parameter logic [7:0]  LINE1_BASE = 8'h80,
  parameter logic [7:0]  LINE2_BASE = 8'hC0,
  parameter int          ROM_AW     = $clog2(2 * LINE_CHARS)
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctrl,
  input  logic [7:0]        romData,
  output logic [7:0]        cmdByte,
  output logic              cmdIsData,
  output logic [ROM_AW-1:0] romAddr,
  output logic              timerLast,
  output logic              isClearItem,
  output logic              isLastItem
);

  localparam int CFG_COUNT = 4;
  localparam int ITEMS     = CFG_COUNT + 2 * (LINE_CHARS + 1);
  localparam int IDX_W     = $clog2(ITEMS);
  localparam int MAX_A     = (SHORT_WAIT > CLEAR_WAIT) ? SHORT_WAIT : CLEAR_WAIT;
  localparam int MAX_WAIT  = (MAX_A > PAUSE_WAIT) ? MAX_A : PAUSE_WAIT;
  localparam int TMR_W     = $clog2(MAX_WAIT + 1);

  localparam logic [IDX_W-1:0] IDX_CLEAR = IDX_W'(CFG_COUNT - 1);
  localparam logic [IDX_W-1:0] IDX_L1SEL = IDX_W'(CFG_COUNT);
  localparam logic [IDX_W-1:0] IDX_L2SEL = IDX_W'(CFG_COUNT + LINE_CHARS + 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(ITEMS - 1);

  localparam logic [7:0] CFG_TABLE [CFG_COUNT] = '{CMD_FUNC, CMD_DISP, CMD_ENTRY, CMD_CLEAR};

  logic [IDX_W-1:0] itemIdx;
  logic [TMR_W-1:0] timer;
  int               addrInt;

  // item counter: configuration, row selects and character bursts share one index
  always_ff @(posedge clk) begin
    if (rst) begin
      itemIdx <= '0;
    end else if (ctrl.clrIdx) begin
      itemIdx <= '0;
    end else if (ctrl.advIdx) begin
      itemIdx <= itemIdx + IDX_W'(1);
    end
  end

  // settling / pause delay counter
  always_ff @(posedge clk) begin
    if (rst) begin
      timer <= '0;
    end else if (ctrl.loadShort) begin
      timer <= TMR_W'(SHORT_WAIT);
    end else if (ctrl.loadClear) begin
      timer <= TMR_W'(CLEAR_WAIT);
    end else if (ctrl.loadPause) begin
      timer <= TMR_W'(PAUSE_WAIT);
    end else if (ctrl.decTimer) begin
      timer <= timer - TMR_W'(1);
    end
  end

  always_comb begin
    cmdByte   = 8'h00;
    cmdIsData = 1'b0;
    addrInt   = 0;
    if (itemIdx < IDX_L1SEL) begin
      cmdByte = CFG_TABLE[itemIdx[1:0]];
    end else if (itemIdx == IDX_L1SEL) begin
      cmdByte = LINE1_BASE;
    end else if (itemIdx < IDX_L2SEL) begin
      cmdIsData = 1'b1;
      addrInt   = int'(itemIdx) - int'(IDX_L1SEL) - 1;
    end else if (itemIdx == IDX_L2SEL) begin
      cmdByte = LINE2_BASE;
    end else begin
      cmdIsData = 1'b1;
      addrInt   = int'(itemIdx) - int'(IDX_L2SEL) - 1 + LINE_CHARS;
    end
    if (cmdIsData) cmdByte = romData;
  end

  assign romAddr     = ROM_AW'(addrInt);
  assign timerLast   = (timer == TMR_W'(1));
  assign isClearItem = (itemIdx == IDX_CLEAR);
  assign isLastItem  = (itemIdx == IDX_LAST);

endmodule

// File: rtl/charLcdSequencer.sv
module charLcdSequencer
  import lcdseq_pkg::*;
#(
  parameter int LINE_CHARS = 40,
  parameter int SHORT_WAIT = 2000,
  parameter int CLEAR_WAIT = 82000,
  parameter int PAUSE_WAIT = 250000,
  parameter int ROM_AW     = $clog2(2 * LINE_CHARS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              req,
  output logic              cmdIsData,
  output logic [7:0]        cmdByte,
  input  logic              xferDone,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [7:0]        romData,
  output logic              frameDone
);

  dpCtrl_t ctrl;
  logic    timerLast;
  logic    isClearItem;
  logic    isLastItem;

  lcdseqCtrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .xferDone    (xferDone),
    .timerLast   (timerLast),
    .isClearItem (isClearItem),
    .isLastItem  (isLastItem),
    .ctrl        (ctrl),
    .req         (req),
    .frameDone   (frameDone)
  );

  lcdseqDatapath #(
    .LINE_CHARS (LINE_CHARS),
    .SHORT_WAIT (SHORT_WAIT),
    .CLEAR_WAIT (CLEAR_WAIT),
    .PAUSE_WAIT (PAUSE_WAIT),
    .ROM_AW     (ROM_AW)
  ) dp_i (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .romData     (romData),
    .cmdByte     (cmdByte),
    .cmdIsData   (cmdIsData),
    .romAddr     (romAddr),
    .timerLast   (timerLast),
    .isClearItem (isClearItem),
    .isLastItem  (isLastItem)
  );

endmodule

// File: rtl/charLcdSeqChecker.sv
module charLcdSeqChecker #(
  parameter int LINE_CHARS = 40,
  parameter int ROM_AW     = $clog2(2 * LINE_CHARS)
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              xferDone,
  input logic              cmdIsData,
  input logic [7:0]        cmdByte,
  input logic [ROM_AW-1:0] romAddr,
  input logic              frameDone
);

  a_r6_request_held: assert property (@(posedge clk) disable iff (rst)
    (req && !xferDone) |=> (req && $stable(cmdByte) && $stable(cmdIsData)));

  a_r6_drop_on_done: assert property (@(posedge clk) disable iff (rst)
    (req && xferDone) |=> !req);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> !frameDone);

  a_r7_pulse_in_gap: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> !req);

  a_r5_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    (req && cmdIsData) |-> (int'(romAddr) < 2 * LINE_CHARS));

  a_r2_cmd_row_select: assert property (@(posedge clk) disable iff (rst)
    $rose(req) && !cmdIsData && cmdByte[7] |-> (cmdByte == 8'h80 || cmdByte == 8'hC0));

endmodule

bind charLcdSequencer charLcdSeqChecker #(
  .LINE_CHARS (LINE_CHARS),
  .ROM_AW     (ROM_AW)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .xferDone  (xferDone),
  .cmdIsData (cmdIsData),
  .cmdByte   (cmdByte),
  .romAddr   (romAddr),
  .frameDone (frameDone)
);

// File: tb/charLcdSequencer_tb_top.sv
module charLcdSequencer_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  LINE_CHARS = 40;
  localparam int  SHORT_WAIT = 3;
  localparam int  CLEAR_WAIT = 9;
  localparam int  PAUSE_WAIT = 20;
  localparam int  ROM_AW     = $clog2(2 * LINE_CHARS);
  localparam int  ITEMS      = 4 + 2 * (LINE_CHARS + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              xferDone = 1'b0;
  logic              req;
  logic              cmdIsData;
  logic [7:0]        cmdByte;
  logic [ROM_AW-1:0] romAddr;
  logic [7:0]        romData;
  logic              frameDone;

  int checks = 0;
  int fails = 0;
  int dfTotal = 0;
  int itemPtr = 0;
  int prevIdx = 0;
  bit haveGap = 0;
  logic [8:0] expQ[$];
  int         expAddr[$];

  function automatic logic [7:0] romFn(int a);
    return 8'(a * 3 + 33);
  endfunction

  assign romData = romFn(int'(romAddr));

  charLcdSequencer #(
    .LINE_CHARS (LINE_CHARS),
    .SHORT_WAIT (SHORT_WAIT),
    .CLEAR_WAIT (CLEAR_WAIT),
    .PAUSE_WAIT (PAUSE_WAIT),
    .ROM_AW     (ROM_AW)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .req       (req),
    .cmdIsData (cmdIsData),
    .cmdByte   (cmdByte),
    .xferDone  (xferDone),
    .romAddr   (romAddr),
    .romData   (romData),
    .frameDone (frameDone)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) if (!rst && frameDone) dfTotal++;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finishRun();
  end

  // serve one transfer; on entry the sample point is just after the previous done edge
  task automatic serveNext();
    int i = itemPtr;
    int lows = 0;
    int dfPos = -1;
    int dfSeen = 0;
    int expLows;
    bit strayDone = (i % 7 == 2);
    bit strayStart = (i % 11 == 5);
    string tag;
    logic [8:0] firstVal;
    if (haveGap) begin
      while (!req && lows < 1000) begin
        lows++;
        if (frameDone) begin dfSeen++; dfPos = lows; end
        xferDone = (lows == 1) && strayDone;
        start    = (lows == 2) && strayStart;
        @(negedge clk);
      end
      xferDone = 1'b0;
      start    = 1'b0;
      if (prevIdx == ITEMS - 1) begin
        expLows = SHORT_WAIT + PAUSE_WAIT;
        check(lows == expLows, "R7 pause gap", lows, expLows);
        check(dfSeen == 1 && dfPos == SHORT_WAIT + 1, "R7 frame pulse position", dfPos, SHORT_WAIT + 1);
      end else begin
        expLows = (prevIdx == 3) ? CLEAR_WAIT : SHORT_WAIT;
        tag = strayDone ? "R6 stray done gap" : (strayStart ? "R8 stray start gap" : "R3 gap");
        check(lows == expLows, tag, lows, expLows);
        check(dfSeen == 0, "R7 no pulse mid pass", dfSeen, 0);
      end
    end
    tag = (i < 4) ? "R2 config command" : (expAddr[i] < 0 ? "R4 row select" : "R4 data byte");
    check(req == 1'b1, tag, int'(req), 1);
    check({cmdIsData, cmdByte} == expQ[i], tag, int'({cmdIsData, cmdByte}), int'(expQ[i]));
    if (expAddr[i] >= 0)
      check(int'(romAddr) == expAddr[i], "R5 text address", int'(romAddr), expAddr[i]);
    firstVal = {cmdIsData, cmdByte};
    for (int h = 0; h < i % 4; h++) begin
      start = (h == 0) && (i % 13 == 6);
      @(negedge clk);
      start = 1'b0;
      check(req && {cmdIsData, cmdByte} == firstVal, "R6 held request", int'({cmdIsData, cmdByte}), int'(firstVal));
    end
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    prevIdx = i;
    itemPtr = (i + 1) % ITEMS;
    haveGap = 1'b1;
  endtask

  initial begin
    expQ.push_back({1'b0, 8'h38}); expAddr.push_back(-1);
    expQ.push_back({1'b0, 8'h0E}); expAddr.push_back(-1);
    expQ.push_back({1'b0, 8'h06}); expAddr.push_back(-1);
    expQ.push_back({1'b0, 8'h01}); expAddr.push_back(-1);
    for (int r = 0; r < 2; r++) begin
      expQ.push_back({1'b0, (r == 0) ? 8'h80 : 8'hC0}); expAddr.push_back(-1);
      for (int c = 0; c < LINE_CHARS; c++) begin
        expQ.push_back({1'b1, romFn(r * LINE_CHARS + c)});
        expAddr.push_back(r * LINE_CHARS + c);
      end
    end

    repeat (3) @(negedge clk);
    check(req == 1'b0, "R1 reset req", int'(req), 0);
    check(frameDone == 1'b0, "R1 reset frameDone", int'(frameDone), 0);
    rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(req == 1'b0, "R1 idle without start", int'(req), 0);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req == 1'b1, "R1 request after start", int'(req), 1);

    for (int n = 0; n < 2 * ITEMS + 31; n++) serveNext();

    // reset in the middle of a pass
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(req == 1'b0 && frameDone == 1'b0, "R9 reset mid pass", int'({req, frameDone}), 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(req == 1'b0, "R9 idle after reset", int'(req), 0);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req == 1'b1 && cmdByte == 8'h38, "R9 restart from function set", int'(cmdByte), 8'h38);
    itemPtr = 0;
    haveGap = 1'b0;
    for (int n = 0; n < ITEMS + 1; n++) serveNext();

    check(dfTotal == 3, "R7 pass count", dfTotal, 3);
    finishRun();
  end

endmodule